// File: doc/BRIEF.md
# Load/Store Multiple Word Sequencer

This block takes one load/store multiple or load/store string instruction from a dispatch stage and cracks it into a stream of word-sized memory operations. Each operation targets one architectural register. It carries that register number, the effective address for the word, the number of bytes to move (1 to 4), a store/load flag and a last-operation marker. Operations leave on a valid/ready interface at a rate of one per cycle. The consumer, normally the load/store unit, can apply back-pressure.

The first operation is presented in the cycle right after the instruction is accepted. It therefore goes out alongside whatever older instructions were dispatched in that cycle, with no bubble. The instruction keeps its dispatch slot until its last operation has been taken, and for no less than two cycles. This holds even for a single-word transfer or for a zero-length indexed string. A one-cycle pulse marks the moment the slot can be freed.

Top module: `lsm_crack_seq`

## Requirements
- R1: After reset, `in_ready` is 1, and `op_valid` and `slot_free` are both 0.
- R2: Kind codes 0 (load multiple) and 1 (store multiple) produce 32−start operations. The registers run from the start register up to 31, the address is base+4k, each operation moves 4 bytes, and `op_store` is 1 only for kind 1.
- R3: Kind codes 2 (load string immediate) and 4 (store string immediate) move `in_nb_imm` bytes, where a value of 0 means 32. They produce ceil(n/4) operations, the register number wraps from 31 to 0, and the last operation carries n mod 4 bytes when that is nonzero. `op_store` is 1 only for kind 4.
- R4: Kind codes 3 (load string indexed) and 5 (store string indexed) move `in_nb_reg` bytes (0 to 127) with the same splitting as R3, and `op_store` is 1 only for kind 5. A count of 0 produces no operation.
- R5: `op_last` is 1 on the final operation of an instruction and on no other operation.
- R6: The first operation is valid in the cycle after acceptance. While `op_ready` is 1, each following operation is valid in the very next cycle.
- R7: While `op_valid` is 1 and `op_ready` is 0, every operation field holds its value.
- R8: `in_ready` stays 0 for max(2, c) cycles after acceptance, where c is the cycle in which the last operation is taken. `slot_free` pulses for exactly one cycle: the first cycle in which `in_ready` is 1 again.
- R9: `in_valid` and the instruction fields are ignored while `in_ready` is 0, and the sequence in progress continues unchanged.
- R10: Kind codes 6 and 7 produce no operation but still hold the slot for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction offered by dispatch |
| in_ready | output | 1 | Sequencer idle, instruction accepted when in_valid is 1 |
| in_kind | input | 3 | Instruction kind code (see R2 to R4, R10) |
| in_rt | input | 5 | First target/source register |
| in_ea | input | 32 | Base effective address |
| in_nb_imm | input | 5 | Immediate byte count for immediate string forms |
| in_nb_reg | input | 7 | Byte count from a register for indexed string forms |
| slot_free | output | 1 | One-cycle pulse: dispatch slot may be released |
| op_valid | output | 1 | Word operation present |
| op_ready | input | 1 | Consumer takes the operation |
| op_reg | output | 5 | Register for this word |
| op_ea | output | 32 | Effective address for this word |
| op_bytes | output | 3 | Bytes in this operation (1 to 4) |
| op_store | output | 1 | 1 for store, 0 for load |
| op_last | output | 1 | Final operation of the instruction |

## Verification
The assertions assume that `op_ready` is driven to a known value in every cycle. They also assume that the instruction fields are meaningful only while `in_valid` is 1 and `in_ready` is 1, so any value is legal outside that window. The bench holds to this by driving `op_ready` on every falling edge. It offers a new instruction only when it expects the sequencer to be idle. During R9 runs it deliberately keeps `in_valid` high with unrelated fields while the sequencer is busy, and it drops `in_valid` in the cycle the sequencer is predicted to leave the busy state, so that no unintended instruction is accepted.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [2:0] {
    K_LD_MULT  = 3'd0,
    K_ST_MULT  = 3'd1,
    K_LD_STR_I = 3'd2,
    K_LD_STR_X = 3'd3,
    K_ST_STR_I = 3'd4,
    K_ST_STR_X = 3'd5
  } lsm_kind_e;

  localparam int WORD_BYTES = 4;
endpackage

// File: rtl/lsm_decode.sv
module lsm_decode #(
  parameter int NREGS  = 32,
  parameter int IMM_W  = 5,
  parameter int XCNT_W = 7,
  parameter int LEN_W  = 8,
  localparam int REG_W = $clog2(NREGS)
) (
  input  logic [2:0]        kind,
  input  logic [REG_W-1:0]  rt,
  input  logic [IMM_W-1:0]  nb_imm,
  input  logic [XCNT_W-1:0] nb_reg,
  output logic [LEN_W-1:0]  total_len,
  output logic              is_store
);
  import lsm_pkg::*;

  localparam int IMM_ZERO_LEN = 1 << IMM_W;

  always_comb begin
    total_len = '0;
    is_store  = 1'b0;
    case (kind)
      K_LD_MULT, K_ST_MULT:
        total_len = LEN_W'((NREGS - int'(rt)) * WORD_BYTES);
      K_LD_STR_I, K_ST_STR_I:
        total_len = (nb_imm == '0) ? LEN_W'(IMM_ZERO_LEN) : LEN_W'(nb_imm);
      K_LD_STR_X, K_ST_STR_X:
        total_len = LEN_W'(nb_reg);
      default:
        total_len = '0;
    endcase
    is_store = (kind == K_ST_MULT) || (kind == K_ST_STR_I) || (kind == K_ST_STR_X);
  end
endmodule

// File: rtl/lsm_slot_ctl.sv
module lsm_slot_ctl #(
  parameter int MIN_HOLD = 2,
  localparam int AGE_W = $clog2(MIN_HOLD + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic op_valid,
  input  logic op_ready,
  input  logic op_last,
  output logic in_ready,
  output logic start,
  output logic busy,
  output logic slot_free
);
  logic [AGE_W-1:0] age;
  logic             finishing;

  assign in_ready  = !busy;
  assign start     = in_valid && !busy;
  assign finishing = !op_valid || (op_valid && op_ready && op_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      age       <= '0;
      slot_free <= 1'b0;
    end else begin
      slot_free <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        age  <= AGE_W'(1);
      end else if (busy) begin
        if (finishing && (int'(age) >= MIN_HOLD)) begin
          busy      <= 1'b0;
          slot_free <= 1'b1;
        end else if (int'(age) < MIN_HOLD) begin
          age <= age + AGE_W'(1);
        end
      end
    end
  end

  // R8: the slot is released only after two busy cycles (MIN_HOLD default 2)
  p_min_hold_r8: assert property (@(posedge clk) disable iff (rst)
    slot_free |-> ($past(busy) && $past(busy, 2)));

  // R8: slot_free lasts exactly one cycle
  p_free_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    slot_free |=> !slot_free);

  // R9: no acceptance while busy, a new sequence starts only from idle
  p_busy_holds_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !finishing) |=> busy);
endmodule

// File: rtl/lsm_opgen.sv
module lsm_opgen #(
  parameter int NREGS  = 32,
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  localparam int REG_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              busy,
  input  logic [REG_W-1:0]  start_reg,
  input  logic [ADDR_W-1:0] start_ea,
  input  logic [LEN_W-1:0]  total_len,
  input  logic              start_store,
  input  logic              op_ready,
  output logic              op_valid,
  output logic [REG_W-1:0]  op_reg,
  output logic [ADDR_W-1:0] op_ea,
  output logic [2:0]        op_bytes,
  output logic              op_store,
  output logic              op_last
);
  import lsm_pkg::*;

  localparam logic [LEN_W-1:0] STEP = LEN_W'(WORD_BYTES);

  logic [LEN_W-1:0] cur_left;
  logic [LEN_W-1:0] next_left;
  logic             take;

  assign take      = op_valid && op_ready;
  assign next_left = cur_left - STEP;

  function automatic logic [2:0] chunk(input logic [LEN_W-1:0] len);
    return (len >= STEP) ? 3'(WORD_BYTES) : len[2:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      op_valid <= 1'b0;
      cur_left <= '0;
      op_reg   <= '0;
      op_ea    <= '0;
      op_bytes <= '0;
      op_store <= 1'b0;
      op_last  <= 1'b0;
    end else if (start) begin
      op_valid <= (total_len != '0);
      cur_left <= total_len;
      op_reg   <= start_reg;
      op_ea    <= start_ea;
      op_bytes <= chunk(total_len);
      op_store <= start_store;
      op_last  <= (total_len <= STEP);
    end else if (take) begin
      if (op_last) begin
        op_valid <= 1'b0;
      end else begin
        cur_left <= next_left;
        op_reg   <= op_reg + REG_W'(1);
        op_ea    <= op_ea + ADDR_W'(WORD_BYTES);
        op_bytes <= chunk(next_left);
        op_last  <= (next_left <= STEP);
      end
    end
  end

  // R7: a stalled operation holds every field
  p_stall_stable_r7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_ready) |=> (op_valid && $stable(op_reg) && $stable(op_ea)
                                 && $stable(op_bytes) && $stable(op_last) && $stable(op_store)));

  // R6: after a non-final take the next word follows at once, one register and one word up
  p_step_r6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready && !op_last) |=>
      (op_valid && op_reg == $past(op_reg) + REG_W'(1)
       && op_ea == $past(op_ea) + ADDR_W'(WORD_BYTES)));

  // R5: only the final operation may be partial
  p_full_unless_last_r5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && !op_last) |-> (op_bytes == 3'(WORD_BYTES)));

  // R3: byte count always in 1..4
  p_bytes_range_r3: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> (op_bytes != 3'd0 && op_bytes <= 3'(WORD_BYTES)));

  // R8: operations appear only while the slot is held
  p_valid_in_slot_r8: assert property (@(posedge clk) disable iff (rst)
    op_valid |-> busy);
endmodule

// File: rtl/lsm_crack_seq.sv
module lsm_crack_seq #(
  parameter int NREGS    = 32,
  parameter int ADDR_W   = 32,
  parameter int IMM_W    = 5,
  parameter int XCNT_W   = 7,
  parameter int MIN_HOLD = 2,
  localparam int REG_W   = $clog2(NREGS),
  localparam int LEN_W   = ((XCNT_W > IMM_W + 1) ? XCNT_W : IMM_W + 1) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_kind,
  input  logic [REG_W-1:0]  in_rt,
  input  logic [ADDR_W-1:0] in_ea,
  input  logic [IMM_W-1:0]  in_nb_imm,
  input  logic [XCNT_W-1:0] in_nb_reg,
  output logic              slot_free,
  output logic              op_valid,
  input  logic              op_ready,
  output logic [REG_W-1:0]  op_reg,
  output logic [ADDR_W-1:0] op_ea,
  output logic [2:0]        op_bytes,
  output logic              op_store,
  output logic              op_last
);
  logic [LEN_W-1:0] total_len;
  logic             is_store;
  logic             start;
  logic             busy;

  lsm_decode #(
    .NREGS(NREGS), .IMM_W(IMM_W), .XCNT_W(XCNT_W), .LEN_W(LEN_W)
  ) u_decode (
    .kind(in_kind), .rt(in_rt), .nb_imm(in_nb_imm), .nb_reg(in_nb_reg),
    .total_len(total_len), .is_store(is_store)
  );

  lsm_slot_ctl #(.MIN_HOLD(MIN_HOLD)) u_slot (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .op_valid(op_valid), .op_ready(op_ready), .op_last(op_last),
    .in_ready(in_ready), .start(start), .busy(busy), .slot_free(slot_free)
  );

  lsm_opgen #(
    .NREGS(NREGS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)
  ) u_opgen (
    .clk(clk), .rst(rst), .start(start), .busy(busy),
    .start_reg(in_rt), .start_ea(in_ea), .total_len(total_len),
    .start_store(is_store), .op_ready(op_ready),
    .op_valid(op_valid), .op_reg(op_reg), .op_ea(op_ea),
    .op_bytes(op_bytes), .op_store(op_store), .op_last(op_last)
  );
endmodule

// File: tb/lsm_crack_seq_bench.sv
module lsm_crack_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_kind = '0;
  logic [4:0]  in_rt = '0;
  logic [31:0] in_ea = '0;
  logic [4:0]  in_nb_imm = '0;
  logic [6:0]  in_nb_reg = '0;
  logic        slot_free;
  logic        op_valid;
  logic        op_ready = 1'b0;
  logic [4:0]  op_reg;
  logic [31:0] op_ea;
  logic [2:0]  op_bytes;
  logic        op_store;
  logic        op_last;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  lsm_crack_seq u_lsm_crack_seq (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_kind(in_kind), .in_rt(in_rt), .in_ea(in_ea),
    .in_nb_imm(in_nb_imm), .in_nb_reg(in_nb_reg), .slot_free(slot_free),
    .op_valid(op_valid), .op_ready(op_ready), .op_reg(op_reg), .op_ea(op_ea),
    .op_bytes(op_bytes), .op_store(op_store), .op_last(op_last)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one instruction; stall: op_ready low on some cycles; junk: keep offering while busy
  task automatic run_one(input int kind, input int rt, input int ea, input int nbi,
                         input int nbr, input bit stall, input bit junk);
    int total, n, k, cyc, e, seen;
    bit st, rdy, leaving;
    string tag;
    case (kind)
      0, 1: begin total = (32 - rt) * 4; tag = "R2"; end
      2, 4: begin total = (nbi == 0) ? 32 : nbi; tag = "R3"; end
      3, 5: begin total = nbr; tag = "R4"; end
      default: begin total = 0; tag = "R10"; end
    endcase
    st = (kind == 1 || kind == 4 || kind == 5);
    n = (total + 3) / 4;
    @(negedge clk);
    chk(in_ready == 1'b1, "R8 idle before issue", longint'(in_ready), 1);
    in_valid = 1'b1; in_kind = 3'(kind); in_rt = 5'(rt); in_ea = 32'(ea);
    in_nb_imm = 5'(nbi); in_nb_reg = 7'(nbr);
    @(posedge clk);
    k = 0; seen = 0;
    e = (n == 0) ? 2 : 1000000;
    for (cyc = 1; cyc < 1000; cyc++) begin
      @(negedge clk);
      if (k == n && cyc > e) begin
        chk(in_ready == 1'b1, "R8 released", longint'(in_ready), 1);
        chk(slot_free == 1'b1, "R8 slot_free pulse", longint'(slot_free), 1);
        chk(op_valid == 1'b0, "R5 no op after last", longint'(op_valid), 0);
        break;
      end
      chk(in_ready == 1'b0, "R8 slot held", longint'(in_ready), 0);
      chk(slot_free == 1'b0, "R8 no early free", longint'(slot_free), 0);
      if (k < n) begin
        int eb;
        eb = (total - 4 * k >= 4) ? 4 : total - 4 * k;
        chk(op_valid == 1'b1, "R6 op present", longint'(op_valid), 1);
        chk(op_reg == 5'((rt + k) % 32) && op_ea == 32'(ea + 4 * k) && op_bytes == 3'(eb)
            && op_store == st, stall ? {tag, "/R7 fields"} : {tag, " fields"},
            longint'({op_reg, op_ea, op_bytes, op_store}),
            longint'({5'((rt + k) % 32), 32'(ea + 4 * k), 3'(eb), st}));
        chk(op_last == (k == n - 1), "R5 last marker", longint'(op_last), longint'(k == n - 1));
      end else begin
        chk(op_valid == 1'b0, (kind >= 6) ? "R10 no op" : {tag, " no op"},
            longint'(op_valid), 0);
      end
      rdy = !(stall && (cyc % 3 == 1));
      op_ready = rdy;
      leaving = (cyc >= 2) && (k == n || (k == n - 1 && rdy));
      if (junk) begin
        in_valid = !leaving;
        in_kind = 3'((kind + 3) % 6); in_rt = 5'(rt ^ 7); in_ea = 32'hDEAD_0000;
        in_nb_imm = 5'd9; in_nb_reg = 7'd77;
      end else begin
        in_valid = 1'b0;
      end
      @(posedge clk);
      if (k < n && rdy) begin
        if (k == n - 1) e = (cyc < 2) ? 2 : cyc;
        k++; seen++;
      end
    end
    in_valid = 1'b0;
    chk(seen == n, junk ? "R9 op count" : {tag, " op count"}, longint'(seen), longint'(n));
    @(negedge clk);
    chk(slot_free == 1'b0, "R8 pulse one cycle", longint'(slot_free), 0);
    op_ready = 1'b0;
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(in_ready == 1'b1, "R1 in_ready", longint'(in_ready), 1);
    chk(op_valid == 1'b0, "R1 op_valid", longint'(op_valid), 0);
    chk(slot_free == 1'b0, "R1 slot_free", longint'(slot_free), 0);
    // R2: both multiple forms, every start register
    for (int kd = 0; kd < 2; kd++)
      for (int r = 0; r < 32; r++)
        run_one(kd, r, 32'h1000 + r * 64, 0, 0, (r % 2) == 1, 1'b0);
    // R3: immediate string forms, every count, start near the top to wrap
    for (int kd = 2; kd <= 4; kd += 2)
      for (int nb = 0; nb < 32; nb++)
        run_one(kd, 26 + (nb % 6), 32'h2001 + nb, nb, 0, (nb % 3) == 0, 1'b0);
    // R4: indexed string forms, every count including 0
    for (int kd = 3; kd <= 5; kd += 2)
      for (int nb = 0; nb < 128; nb++)
        run_one(kd, nb % 32, 32'h8000 + nb * 3, 0, nb, (nb % 4) == 2, 1'b0);
    // R10: unused kind codes
    run_one(6, 3, 32'h40, 5, 9, 1'b0, 1'b0);
    run_one(7, 30, 32'h44, 0, 100, 1'b1, 1'b0);
    // R9: keep offering instructions while busy
    run_one(0, 20, 32'h500, 0, 0, 1'b0, 1'b1);
    run_one(4, 31, 32'h600, 7, 0, 1'b1, 1'b1);
    run_one(5, 0, 32'h700, 0, 0, 1'b0, 1'b1);
    run_one(2, 10, 32'h800, 1, 0, 1'b0, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule